// File: doc/BRIEF.md
# Multi-Channel Block Transfer Controller

The block is a small direct memory access engine with a parameterised number of channels (four by default). Each channel has a source address, a destination address, a word count and a control word. Software loads these through a valid/ready register port, and that port accepts writes only while the engine is idle. When an enabled channel raises its request line, the engine asks the processor for the bus with `hold_req`. It waits for `hold_grant`, acknowledges the winning device and then moves the whole block of words for that channel inside one period of bus ownership.

Device-to-memory and memory-to-device words are fly-by transfers. Each takes a four-state working cycle: the address in the first state, the read strobe in the second and third, and the write strobe in the third. A memory-to-memory word takes two four-state phases back to back. In the read phase the source word is captured into an internal holding register. In the write phase that word is driven out to the destination address. When the count runs out, the engine drops `hold_req`, disables the channel and sets that channel's interrupt flag. The flag stays set until software clears it.

Register port handshake: a write takes effect on a clock edge where `reg_valid` and `reg_ready` are both high. `reg_ready` is high only in the idle state. While the engine owns the bus, the master must hold its write until ready returns. A write presented and then withdrawn during that time has no effect. `reg_wdata` is `AW` bits wide, and `CNTW` must not exceed `AW`.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, `hold_req`, `dack`, all strobes, `data_oe`, `irq` and `irq_flags` are low, `reg_ready` is high and every channel is disabled.
- R2: `reg_addr` = {global, channel, field}. The fields are 0 = source address, 1 = destination address, 2 = count, 3 = control (bit 0 enable, bits 2:1 mode). A write lands only when `reg_valid && reg_ready`. `reg_ready` is high exactly in the idle state, so a write offered while the bus is owned changes nothing.
- R3: A channel is considered only when it is enabled and its `dreq` bit is high. Otherwise the engine stays idle with `hold_req` low.
- R4: A qualifying request raises `hold_req` one cycle later. No working state, strobe or `dack` appears before `hold_grant` is seen. The first working state follows the cycle in which the grant is sampled.
- R5: Among simultaneous requests the lowest channel index wins. At most one `dack` bit is high, and only one channel is served per ownership period.
- R6: In mode 0 (device to memory) each word takes four states with `mem_addr` = source address. `io_rd` is high in states 2 and 3, and `mem_wr` is high in state 3.
- R7: In mode 1 (memory to device) `mem_rd` is high in states 2 and 3, and `io_wr` is high in state 3, with the same address timing as R6.
- R8: In mode 2 (memory to memory) each word takes eight states. In read states 1 to 4 the address is the source, `mem_rd` is high in states 2 and 3, and `data_in` is captured at the end of state 3. In write states 1 to 4 the address is the destination, `data_oe` is high with `data_out` equal to the captured word in states 2 and 3, and `mem_wr` is high in state 3.
- R9: Addresses increase by one per word and wrap modulo 2^AW. A loaded count N moves N+1 words.
- R10: After the last word, `hold_req` and `dack` go low, the channel's `irq_flags` bit and `irq` go high, and the channel is disabled, so later requests on it are ignored.
- R11: Interrupt flags stay set until a global write (`reg_addr` top bit 1) clears the flags whose `reg_wdata` bits are 1. Other flags are kept, and `irq` is the OR of the flags.
- R12: Mode 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register write offered |
| reg_ready | output | 1 | Register port accepts writes (idle only) |
| reg_addr | input | CW+3 | {global, channel, field} |
| reg_wdata | input | AW | Register write data |
| dreq | input | NCH | Device request lines |
| dack | output | NCH | Device acknowledge lines |
| hold_req | output | 1 | Bus request to processor |
| hold_grant | input | 1 | Bus grant from processor |
| mem_addr | output | AW | Transfer address during working states |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| data_in | input | DW | Read data for memory-to-memory moves |
| data_out | output | DW | Held word during memory-to-memory write phase |
| data_oe | output | 1 | Drive enable for data_out |
| irq | output | 1 | Level interrupt, OR of flags |
| irq_flags | output | NCH | Per-channel completion flags |

## Verification
Several properties are checked on every cycle by the assertions. At most one acknowledge is active. No strobe or acknowledge appears without a bus request, and the first acknowledge follows a sampled grant. Read and write strobes of the same kind never overlap. The interrupt is high when the request falls and holds until a clear write. The bench scenarios cover what the assertions cannot see: the exact state-by-state strobe and address sequence in each mode, address wrap, the N+1 word count, the value carried through the holding register, the priority order, writes withdrawn while busy, and a finished channel staying disabled.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD,
    ST_S1, ST_S2, ST_S3, ST_S4,
    ST_R1, ST_R2, ST_R3, ST_R4,
    ST_W1, ST_W2, ST_W3, ST_W4
  } dma_state_e;

  localparam logic [1:0] MODE_D2M = 2'd0;
  localparam logic [1:0] MODE_M2D = 2'd1;
  localparam logic [1:0] MODE_M2M = 2'd2;

  localparam logic [1:0] FLD_SRC  = 2'd0;
  localparam logic [1:0] FLD_DST  = 2'd1;
  localparam logic [1:0] FLD_CNT  = 2'd2;
  localparam logic [1:0] FLD_CTRL = 2'd3;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH = 4,
  parameter int AW = 16,
  parameter int CNTW = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CW-1:0]              wr_ch,
  input  logic [1:0]                 wr_field,
  input  logic [AW-1:0]              wr_data,
  input  logic [CW-1:0]              sel,
  input  logic                       adv_src,
  input  logic                       adv_dst,
  input  logic                       dec_cnt,
  input  logic                       finish,
  output logic [NCH-1:0][AW-1:0]     src_q,
  output logic [NCH-1:0][AW-1:0]     dst_q,
  output logic [NCH-1:0][CNTW-1:0]   cnt_q,
  output logic [NCH-1:0][1:0]        mode_q,
  output logic [NCH-1:0]             en_q
);
  import dma_pkg::*;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [AW-1:0]   src_r, dst_r;
    logic [CNTW-1:0] cnt_r;
    logic [1:0]      mode_r;
    logic            en_r;
    logic            hit_wr, hit_sel;

    assign hit_wr  = wr_en && (wr_ch == CW'(c));
    assign hit_sel = (sel == CW'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_r  <= '0;
        dst_r  <= '0;
        cnt_r  <= '0;
        mode_r <= '0;
        en_r   <= 1'b0;
      end else begin
        if (hit_wr) begin
          unique case (wr_field)
            FLD_SRC:  src_r <= wr_data;
            FLD_DST:  dst_r <= wr_data;
            FLD_CNT:  cnt_r <= wr_data[CNTW-1:0];
            FLD_CTRL: begin
              en_r   <= wr_data[0];
              mode_r <= wr_data[2:1];
            end
          endcase
        end
        if (hit_sel) begin
          if (adv_src) src_r <= src_r + 1'b1;
          if (adv_dst) dst_r <= dst_r + 1'b1;
          if (dec_cnt) cnt_r <= cnt_r - 1'b1;
          if (finish)  en_r  <= 1'b0;
        end
      end
    end

    assign src_q[c]  = src_r;
    assign dst_q[c]  = dst_r;
    assign cnt_q[c]  = cnt_r;
    assign mode_q[c] = mode_r;
    assign en_q[c]   = en_r;
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CW-1:0]  idx
);
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = CW'(i);
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       grant,
  input  logic [1:0] mode,
  input  logic       last,
  output logic       idle,
  output logic       working,
  output logic       use_dst,
  output logic       rd_mem,
  output logic       wr_mem,
  output logic       rd_io,
  output logic       wr_io,
  output logic       drive,
  output logic       cap,
  output logic       adv_src,
  output logic       adv_dst,
  output logic       dec_cnt,
  output logic       finish
);
  import dma_pkg::*;

  dma_state_e st_q, st_d;
  logic m2d;

  assign m2d = (mode == MODE_M2D);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_HOLD;
      ST_HOLD: if (grant) st_d = (mode == MODE_M2M) ? ST_R1 : ST_S1;
      ST_S1:   st_d = ST_S2;
      ST_S2:   st_d = ST_S3;
      ST_S3:   st_d = ST_S4;
      ST_S4:   st_d = last ? ST_IDLE : ST_S1;
      ST_R1:   st_d = ST_R2;
      ST_R2:   st_d = ST_R3;
      ST_R3:   st_d = ST_R4;
      ST_R4:   st_d = ST_W1;
      ST_W1:   st_d = ST_W2;
      ST_W2:   st_d = ST_W3;
      ST_W3:   st_d = ST_W4;
      ST_W4:   st_d = last ? ST_IDLE : ST_R1;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign idle    = (st_q == ST_IDLE);
  assign working = !(st_q inside {ST_IDLE, ST_HOLD});
  assign use_dst = (st_q inside {ST_W1, ST_W2, ST_W3, ST_W4});
  assign rd_io   = !m2d && (st_q inside {ST_S2, ST_S3});
  assign rd_mem  = (m2d && (st_q inside {ST_S2, ST_S3})) || (st_q inside {ST_R2, ST_R3});
  assign wr_io   = m2d && (st_q == ST_S3);
  assign wr_mem  = (!m2d && (st_q == ST_S3)) || (st_q == ST_W3);
  assign drive   = (st_q inside {ST_W2, ST_W3});
  assign cap     = (st_q == ST_R3);
  assign adv_src = (st_q == ST_S4) || (st_q == ST_R4);
  assign adv_dst = (st_q == ST_W4);
  assign dec_cnt = (st_q == ST_S4) || (st_q == ST_W4);
  assign finish  = dec_cnt && last;
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl #(
  parameter int NCH = 4,
  parameter int AW = 16,
  parameter int CNTW = 16,
  parameter int DW = 16,
  localparam int CW = $clog2(NCH),
  localparam int RAW = CW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_valid,
  output logic            reg_ready,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  input  logic [NCH-1:0]  dreq,
  output logic [NCH-1:0]  dack,
  output logic            hold_req,
  input  logic            hold_grant,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            io_rd,
  output logic            io_wr,
  input  logic [DW-1:0]   data_in,
  output logic [DW-1:0]   data_out,
  output logic            data_oe,
  output logic            irq,
  output logic [NCH-1:0]  irq_flags
);
  logic                     wr_fire, wr_glob, wr_chan;
  logic [NCH-1:0][AW-1:0]   src_q, dst_q;
  logic [NCH-1:0][CNTW-1:0] cnt_q;
  logic [NCH-1:0][1:0]      mode_q;
  logic [NCH-1:0]           en_q;
  logic                     any_req, start, last, idle, working, use_dst, drive, cap;
  logic                     adv_src, adv_dst, dec_cnt, finish;
  logic [CW-1:0]            win_idx, sel_q;
  logic [DW-1:0]            tmp_q;
  logic [NCH-1:0]           irq_q;

  assign wr_fire = reg_valid && reg_ready;
  assign wr_glob = wr_fire && reg_addr[RAW-1];
  assign wr_chan = wr_fire && !reg_addr[RAW-1];

  dma_chan_regs #(.NCH(NCH), .AW(AW), .CNTW(CNTW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_chan), .wr_ch(reg_addr[CW+1:2]), .wr_field(reg_addr[1:0]), .wr_data(reg_wdata),
    .sel(sel_q), .adv_src(adv_src), .adv_dst(adv_dst), .dec_cnt(dec_cnt), .finish(finish),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .mode_q(mode_q), .en_q(en_q)
  );

  dma_prio_arb #(.NCH(NCH)) arb_i (
    .req(dreq & en_q), .any(any_req), .idx(win_idx)
  );

  assign start = idle && any_req;
  assign last  = (cnt_q[sel_q] == '0);

  dma_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .grant(hold_grant),
    .mode(mode_q[sel_q]), .last(last),
    .idle(idle), .working(working), .use_dst(use_dst),
    .rd_mem(mem_rd), .wr_mem(mem_wr), .rd_io(io_rd), .wr_io(io_wr),
    .drive(drive), .cap(cap), .adv_src(adv_src), .adv_dst(adv_dst),
    .dec_cnt(dec_cnt), .finish(finish)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      tmp_q <= '0;
      irq_q <= '0;
    end else begin
      if (start) sel_q <= win_idx;
      if (cap)   tmp_q <= data_in;
      if (wr_glob) irq_q <= irq_q & ~reg_wdata[NCH-1:0];
      else if (finish) irq_q <= irq_q | (NCH'(1) << sel_q);
    end
  end

  assign reg_ready = idle;
  assign hold_req  = !idle;
  assign dack      = working ? (NCH'(1) << sel_q) : '0;
  assign mem_addr  = !working ? '0 : (use_dst ? dst_q[sel_q] : src_q[sel_q]);
  assign data_oe   = drive;
  assign data_out  = drive ? tmp_q : '0;
  assign irq_flags = irq_q;
  assign irq       = |irq_q;
endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
  parameter int NCH = 4,
  parameter int RAW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_valid,
  input logic           reg_ready,
  input logic [RAW-1:0] reg_addr,
  input logic [NCH-1:0] dack,
  input logic           hold_req,
  input logic           hold_grant,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic           io_rd,
  input logic           io_wr,
  input logic           data_oe,
  input logic           irq
);
  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dack));
  // R4
  bus_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dack != '0) || mem_rd || mem_wr || io_rd || io_wr || data_oe) |-> hold_req);
  // R4
  grant_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dack) |-> $past(hold_grant));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && !(io_rd && io_wr));
  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n) hold_req |-> !reg_ready);
  // R8
  drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!mem_rd && !io_rd && !io_wr));
  // R10
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(hold_req) |-> irq);
  // R11
  irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_valid && reg_ready && reg_addr[RAW-1])) |=> irq);
endmodule

bind dma_ctrl dma_ctrl_chk #(.NCH(NCH), .RAW(RAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
  .reg_addr(reg_addr), .dack(dack), .hold_req(hold_req), .hold_grant(hold_grant),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
  .data_oe(data_oe), .irq(irq)
);

// File: tb/dma_ctrl_tb_top.sv
module dma_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int RAW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_ready;
  logic [RAW-1:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [NCH-1:0] dreq = '0, dack;
  logic hold_req, hold_grant = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, io_rd, io_wr, data_oe, irq;
  logic [DW-1:0] data_in = '0, data_out;
  logic [NCH-1:0] irq_flags;

  int checks = 0, errors = 0;
  logic [AW-1:0] m_src [NCH];
  logic [AW-1:0] m_dst [NCH];
  logic [AW-1:0] m_cnt [NCH];
  logic [1:0]    m_mode [NCH];
  logic [NCH-1:0] m_irq = '0;

  always #10 clk = ~clk;

  dma_ctrl dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] exp_strobes(input logic [1:0] mode, input int ph);
    // order {mem_rd, mem_wr, io_rd, io_wr, data_oe}
    if (mode == 2'd2) begin
      if (ph == 1 || ph == 2) return 5'b10000;
      if (ph == 5) return 5'b00001;
      if (ph == 6) return 5'b01001;
      return 5'b00000;
    end
    if (mode == 2'd1) begin
      if (ph == 1) return 5'b10000;
      if (ph == 2) return 5'b10010;
      return 5'b00000;
    end
    if (ph == 1) return 5'b00100;
    if (ph == 2) return 5'b01100;
    return 5'b00000;
  endfunction

  function automatic logic [DW-1:0] word_val(input int ch, input int w);
    return DW'(16'hC300 + w * 7 + ch);
  endfunction

  task automatic wr(input logic [RAW-1:0] a, input logic [AW-1:0] d);
    reg_valid = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [1:0] mode, input logic [AW-1:0] src,
                      input logic [AW-1:0] dst, input logic [AW-1:0] cnt);
    wr({1'b0, 2'(ch), 2'd0}, src);
    wr({1'b0, 2'(ch), 2'd1}, dst);
    wr({1'b0, 2'(ch), 2'd2}, cnt);
    wr({1'b0, 2'(ch), 2'd3}, {13'd0, mode, 1'b1});
    m_src[ch] = src; m_dst[ch] = dst; m_cnt[ch] = cnt; m_mode[ch] = mode;
  endtask

  task automatic clear_irq(input logic [NCH-1:0] bits);
    wr({1'b1, 4'd0}, {12'd0, bits});
    m_irq = m_irq & ~bits;
  endtask

  // entered at a negedge where the request is already pending
  task automatic serve(input int ch, input int gdelay, input bit poke);
    int nph;
    logic [DW-1:0] held;
    nph = (m_mode[ch] == 2'd2) ? 8 : 4;
    held = '0;
    check("R4 hold_req raised", {31'd0, hold_req}, 32'd1);
    for (int i = 0; i < gdelay; i++) begin
      @(negedge clk);
      check("R4 no ack before grant", {hold_req, dack}, {1'b1, 4'd0});
    end
    hold_grant = 1'b1;
    for (int w = 0; w <= int'(m_cnt[ch]); w++) begin
      for (int p = 0; p < nph; p++) begin
        if (nph == 8 && p == 0) data_in = word_val(ch, w);
        @(negedge clk);
        check("R6/R7/R8 strobes", {27'd0, mem_rd, mem_wr, io_rd, io_wr, data_oe},
              {27'd0, exp_strobes(m_mode[ch], p)});
        check("R9 address", {16'd0, mem_addr}, {16'd0, (p >= 4) ? m_dst[ch] : m_src[ch]});
        check("R5 dack", {28'd0, dack}, {28'd0, 4'(1 << ch)});
        if (nph == 8 && p == 3) held = word_val(ch, w);
        if (data_oe) check("R8 held word", {16'd0, data_out}, {16'd0, held});
        if (poke && w == 0 && p == 1) begin
          check("R2 not ready when busy", {31'd0, reg_ready}, 32'd0);
          reg_valid = 1'b1; reg_addr = {1'b0, 2'(ch), 2'd0}; reg_wdata = 16'h5555;
        end
        if (poke && w == 0 && p == 3) reg_valid = 1'b0;
        if (p == 3) m_src[ch] = m_src[ch] + 1'b1;
        if (p == 7) m_dst[ch] = m_dst[ch] + 1'b1;
      end
    end
    @(negedge clk);
    m_irq[ch] = 1'b1;
    check("R10 release", {hold_req, dack}, 5'd0);
    check("R10 irq flags", {27'd0, irq, irq_flags}, {27'd0, 1'b1, m_irq});
    hold_grant = 1'b0;
    dreq[ch] = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 reset outputs", {dack, hold_req, mem_rd, mem_wr, io_rd, io_wr, data_oe, irq, irq_flags},
          '0);
    check("R1 ready", {31'd0, reg_ready}, 32'd1);

    // R3: request on a channel that is not enabled
    dreq[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 disabled ignored", {31'd0, hold_req}, 32'd0);
    dreq[0] = 1'b0;

    // R6, R9, R2: device to memory, three words, poke while busy
    prog(0, 2'd0, 16'h1000, 16'h0, 16'd2);
    dreq[0] = 1'b1; @(negedge clk);
    serve(0, 2, 1'b1);

    // R7: single word memory to device
    prog(1, 2'd1, 16'h0ABC, 16'h0, 16'd0);
    dreq[1] = 1'b1; @(negedge clk);
    serve(1, 0, 1'b0);

    // R8: memory to memory
    prog(2, 2'd2, 16'h2000, 16'h3000, 16'd2);
    dreq[2] = 1'b1; @(negedge clk);
    serve(2, 1, 1'b0);

    // R12 with R9 wrap
    prog(3, 2'd3, 16'hFFFF, 16'h0, 16'd1);
    dreq[3] = 1'b1; @(negedge clk);
    serve(3, 0, 1'b0);

    // R10: finished channel stays disabled
    dreq[3] = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 disabled after done", {31'd0, hold_req}, 32'd0);
    dreq[3] = 1'b0;

    // R11: partial clear
    clear_irq(4'b0011);
    check("R11 partial clear", {27'd0, irq, irq_flags}, {27'd0, 1'b1, 4'b1100});
    clear_irq(4'b1100);
    check("R11 full clear", {27'd0, irq, irq_flags}, 32'd0);

    // R5: simultaneous requests
    prog(1, 2'd0, 16'h4000, 16'h0, 16'd1);
    prog(3, 2'd1, 16'h5000, 16'h0, 16'd0);
    dreq = 4'b1010; @(negedge clk);
    serve(1, 1, 1'b0);
    @(negedge clk);
    serve(3, 0, 1'b0);
    clear_irq(4'b1111);

    for (int it = 0; it < 25; it++) begin
      int ch;
      ch = int'($urandom % NCH);
      prog(ch, 2'($urandom % 4), 16'($urandom), 16'($urandom), 16'($urandom % 5));
      dreq[ch] = 1'b1; @(negedge clk);
      serve(ch, int'($urandom % 4), 1'($urandom % 2));
      clear_irq(4'(1 << ch));
      check("R11 cleared", {31'd0, irq}, 32'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule